// File: doc/BRIEF.md
# DMA Channel Loop Iteration Controller

This block sequences the transfer of one DMA channel. A service request, from a hardware request line or from a software start, makes the channel active. It then issues read/write access pairs to an external bus engine until the programmed per-request byte count is used up. That count is split into accesses whose width is a power of two. The completion of those accesses forms one minor loop. At the end of each minor loop the block steps the current iteration counter down by one. When the counter would reach zero, the major loop is complete: the counter is reloaded from the beginning count and the completion actions fire.

The completion actions are a done flag, optional interrupts at the half-way point and at the end, an optional automatic clear of the channel's hardware-request enable, and start requests to other channels. Those link requests follow the minor-loop and major-loop settings. A continuous mode lets a channel whose minor link points to itself restart without going back through arbitration. A programmable stall inserts idle cycles after every access pair to limit bus bandwidth. A cancel, in a plain form or an error form, cuts the minor loop short once the current access pair is finished.

Address generation and the bus protocol belong to other blocks. This controller only drives the read and write requests and takes back their completion handshakes.

Top module: `dma_loop_ctrl`

## Requirements
- R1: After reset, active, rd_req, wr_req, int_flag, done_flag, req_en, link_start, cfg_err and cancel_err are 0, and cur_iter is 0.
- R2: One minor loop issues ceil(nbytes / 2^cfg_size) access pairs. cfg_size is the log2 of the access width in bytes. In each pair, wr_req is raised only after rd_done has been seen for that pair's read.
- R3: Each minor-loop end gives a one-cycle minor_done pulse, and cur_iter drops by one unless the major loop completes.
- R4: When a minor loop ends with cur_iter at 1, the following happen together: a one-cycle major_done pulse, a reload of cur_iter from the beginning count, done_flag set, and active low in the next cycle.
- R5: With cfg_int_major set, major completion sets int_flag. clr_int clears int_flag and clr_done clears done_flag.
- R6: With cfg_int_half set, int_flag is set at the minor-loop end whose new count equals the beginning count shifted right by one.
- R7: With cfg_auto_off set, major completion clears req_en. No further hardware-requested loop then starts.
- R8: hw_req starts the channel only while req_en is 1. A sw_start pulse starts it whenever the loaded descriptor is valid.
- R9: cfg_stall selects the idle cycles inserted after every access pair: code 2 gives 4, code 3 gives 8, and codes 0 and 1 give none.
- R10: At major completion with cfg_major_link set, link_start pulses with link_ch = cfg_major_ch. At any other minor-loop end with cfg_minor_link set, link_start pulses with link_ch = cfg_minor_ch.
- R11: With cont_mode set and cfg_minor_ch equal to the channel's own number, a minor-loop end that is not the last one restarts the next minor loop at once. active stays high and link_start does not pulse.
- R12: cancel or err_cancel, while active, ends the minor loop after the current access pair and retires it as a completed minor loop. err_cancel also sets cancel_err. A cancel while idle has no effect on the next loop.
- R13: A load with nbytes = 0, a beginning count of 0, or a beginning count different from the current count sets cfg_err. No start is accepted until a valid load; clr_err clears cfg_err and cancel_err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_load | input | 1 | Load descriptor fields (accepted while idle) |
| cfg_nbytes | input | NB_W | Bytes per minor loop |
| cfg_biter | input | IT_W | Beginning iteration count |
| cfg_citer | input | IT_W | Current iteration count at load |
| cfg_size | input | SZ_W | Log2 of access width in bytes |
| cfg_stall | input | 2 | Post-pair stall code |
| cfg_int_half | input | 1 | Half-way interrupt enable |
| cfg_int_major | input | 1 | Major-completion interrupt enable |
| cfg_auto_off | input | 1 | Clear request enable at major completion |
| cfg_req_en | input | 1 | Hardware request enable value loaded |
| cfg_major_link | input | 1 | Major-loop channel link enable |
| cfg_major_ch | input | CH_W | Channel started at major completion |
| cfg_minor_link | input | 1 | Minor-loop channel link enable |
| cfg_minor_ch | input | CH_W | Channel started at minor-loop end |
| cont_mode | input | 1 | Continuous self-link mode |
| hw_req | input | 1 | Hardware service request (level) |
| sw_start | input | 1 | Software start pulse |
| cancel | input | 1 | Cancel pulse |
| err_cancel | input | 1 | Cancel-as-error pulse |
| clr_int | input | 1 | Clear interrupt flag |
| clr_done | input | 1 | Clear done flag |
| clr_err | input | 1 | Clear error flags |
| rd_done | input | 1 | Read access completed |
| wr_done | input | 1 | Write access completed |
| rd_req | output | 1 | Read access request |
| wr_req | output | 1 | Write access request |
| minor_done | output | 1 | Minor-loop end pulse |
| major_done | output | 1 | Major-loop end pulse |
| int_flag | output | 1 | Channel interrupt flag |
| done_flag | output | 1 | Major completion flag |
| req_en | output | 1 | Hardware request enable |
| link_start | output | 1 | Start pulse for a linked channel |
| link_ch | output | CH_W | Linked channel number |
| active | output | 1 | Channel executing |
| cur_iter | output | IT_W | Current iteration count |
| cfg_err | output | 1 | Descriptor configuration error |
| cancel_err | output | 1 | Transfer cancelled as error |

## Verification
The hardest case to reach from the ports is a cancel that arrives during the read half of a pair. The pair must still finish with its write, and then no further read may follow. The bench therefore counts read handshakes as its bus responder grants them. It raises the cancel right after a chosen read is granted, so the expected number of reads in that loop is known exactly. Random descriptors mix every stall code, link setting and continuous self-link. The bench then checks access counts, idle-cycle counts, pulse counts and the last linked channel against closed-form bench functions.

// File: rtl/dma_loop_pkg.sv
package dma_loop_pkg;

   typedef enum logic [2:0] {
      SQ_IDLE  = 3'd0,
      SQ_RD    = 3'd1,
      SQ_WR    = 3'd2,
      SQ_STALL = 3'd3,
      SQ_END   = 3'd4
   } sq_state_t;

   // idle cycles after an access pair for a given throttle code
   function automatic logic [3:0] stall_cycles(input logic [1:0] code);
      case (code)
         2'd2:    stall_cycles = 4'd4;
         2'd3:    stall_cycles = 4'd8;
         default: stall_cycles = 4'd0;
      endcase
   endfunction

endpackage

// File: rtl/dma_xfer_seq.sv
module dma_xfer_seq
   import dma_loop_pkg::*;
#(
   parameter int unsigned NB_W     = 16,
   parameter int unsigned SZ_W     = 3,
   parameter bit          STALL_EN = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            go,
   input  logic            chain,
   input  logic            cut,
   input  logic [NB_W-1:0] nbytes,
   input  logic [SZ_W-1:0] size_log2,
   input  logic [1:0]      stall_code,
   input  logic            rd_done,
   input  logic            wr_done,
   output logic            rd_req,
   output logic            wr_req,
   output logic            minor_end,
   output logic            busy,
   output logic            cut_taken
);

   localparam int unsigned MAX_UNIT_LOG = (1 << SZ_W) - 1;

   if (NB_W <= MAX_UNIT_LOG) begin : g_bad_width
      $error("dma_xfer_seq: NB_W too small for the largest access width");
   end

   sq_state_t       st;
   logic [NB_W-1:0] rem;
   logic [3:0]      stall_cnt;
   logic [3:0]      stall_n;
   logic            cut_q;
   logic [NB_W-1:0] unit;
   logic            last_pair;

   if (STALL_EN) begin : g_stall
      assign stall_n = stall_cycles(stall_code);
   end else begin : g_no_stall
      logic unused_code;
      assign unused_code = ^stall_code;
      assign stall_n     = 4'd0;
   end

   assign unit      = NB_W'(1) << size_log2;
   assign last_pair = (rem <= unit) | cut;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= SQ_IDLE;
         rem       <= '0;
         stall_cnt <= '0;
         cut_q     <= 1'b0;
      end else begin
         case (st)
            SQ_IDLE: begin
               if (go) begin
                  st    <= SQ_RD;
                  rem   <= nbytes;
                  cut_q <= 1'b0;
               end
            end
            SQ_RD: begin
               if (rd_done) st <= SQ_WR;
            end
            SQ_WR: begin
               if (wr_done) begin
                  if (stall_n != 4'd0) begin
                     st        <= SQ_STALL;
                     stall_cnt <= stall_n - 4'd1;
                  end else if (last_pair) begin
                     st    <= SQ_END;
                     cut_q <= cut;
                  end else begin
                     st  <= SQ_RD;
                     rem <= rem - unit;
                  end
               end
            end
            SQ_STALL: begin
               if (stall_cnt == 4'd0) begin
                  if (last_pair) begin
                     st    <= SQ_END;
                     cut_q <= cut;
                  end else begin
                     st  <= SQ_RD;
                     rem <= rem - unit;
                  end
               end else begin
                  stall_cnt <= stall_cnt - 4'd1;
               end
            end
            SQ_END: begin
               if (chain) begin
                  st    <= SQ_RD;
                  rem   <= nbytes;
                  cut_q <= 1'b0;
               end else begin
                  st <= SQ_IDLE;
               end
            end
            default: st <= SQ_IDLE;
         endcase
      end
   end

   assign rd_req    = (st == SQ_RD);
   assign wr_req    = (st == SQ_WR);
   assign minor_end = (st == SQ_END);
   assign busy      = (st != SQ_IDLE);
   assign cut_taken = minor_end & cut_q;

   // R2
   wr_after_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wr_req) |-> $past(rd_done));

endmodule

// File: rtl/dma_iter_cnt.sv
module dma_iter_cnt #(
   parameter int unsigned IT_W = 9
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic [IT_W-1:0] ld_biter,
   input  logic [IT_W-1:0] ld_citer,
   input  logic            step,
   input  logic            half_en,
   input  logic            major_en,
   input  logic            clr_int,
   input  logic            clr_done,
   output logic [IT_W-1:0] citer,
   output logic            last_iter,
   output logic            int_flag,
   output logic            done_flag,
   output logic            minor_pulse,
   output logic            major_pulse
);

   if (IT_W < 2) begin : g_bad_width
      $error("dma_iter_cnt: IT_W must be at least 2");
   end

   logic [IT_W-1:0] biter;
   logic [IT_W-1:0] nxt;
   logic            half_hit;
   logic            int_set;

   assign last_iter = (citer == IT_W'(1));
   assign nxt       = citer - IT_W'(1);
   assign half_hit  = (nxt == (biter >> 1));
   assign int_set   = step & ((major_en & last_iter) | (half_en & half_hit));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         biter       <= '0;
         citer       <= '0;
         int_flag    <= 1'b0;
         done_flag   <= 1'b0;
         minor_pulse <= 1'b0;
         major_pulse <= 1'b0;
      end else begin
         minor_pulse <= step;
         major_pulse <= step & last_iter;
         if (load) begin
            biter <= ld_biter;
            citer <= ld_citer;
         end else if (step) begin
            citer <= last_iter ? biter : nxt;
         end
         if (int_set)      int_flag <= 1'b1;
         else if (clr_int) int_flag <= 1'b0;
         if (step & last_iter) done_flag <= 1'b1;
         else if (clr_done)    done_flag <= 1'b0;
      end
   end

   // R4
   reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      major_pulse |-> (citer == biter) && done_flag);

   // R3
   step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (minor_pulse && !major_pulse) |-> (citer == $past(citer) - IT_W'(1)));

endmodule

// File: rtl/dma_link_sel.sv
module dma_link_sel #(
   parameter int unsigned CH_W  = 5,
   parameter int unsigned CH_ID = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            step,
   input  logic            last_iter,
   input  logic            cut_taken,
   input  logic            cont_mode,
   input  logic            minor_en,
   input  logic [CH_W-1:0] minor_ch,
   input  logic            major_en,
   input  logic [CH_W-1:0] major_ch,
   output logic            chain,
   output logic            link_start,
   output logic [CH_W-1:0] link_ch
);

   if (CH_ID >= (1 << CH_W)) begin : g_bad_id
      $error("dma_link_sel: CH_ID does not fit in CH_W bits");
   end

   localparam logic [CH_W-1:0] SELF = CH_W'(CH_ID);

   logic self_loop;

   assign self_loop = minor_en & cont_mode & (minor_ch == SELF);
   assign chain     = step & self_loop & ~last_iter & ~cut_taken;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         link_start <= 1'b0;
         link_ch    <= '0;
      end else begin
         link_start <= 1'b0;
         if (step) begin
            if (last_iter) begin
               if (major_en) begin
                  link_start <= 1'b1;
                  link_ch    <= major_ch;
               end
            end else if (minor_en && !self_loop) begin
               link_start <= 1'b1;
               link_ch    <= minor_ch;
            end
         end
      end
   end

   // R10
   link_after_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      link_start |-> $past(step));

endmodule

// File: rtl/dma_loop_ctrl.sv
module dma_loop_ctrl #(
   parameter int unsigned NB_W     = 16,
   parameter int unsigned IT_W     = 9,
   parameter int unsigned CH_W     = 5,
   parameter int unsigned SZ_W     = 3,
   parameter int unsigned CH_ID    = 3,
   parameter bit          STALL_EN = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cfg_load,
   input  logic [NB_W-1:0] cfg_nbytes,
   input  logic [IT_W-1:0] cfg_biter,
   input  logic [IT_W-1:0] cfg_citer,
   input  logic [SZ_W-1:0] cfg_size,
   input  logic [1:0]      cfg_stall,
   input  logic            cfg_int_half,
   input  logic            cfg_int_major,
   input  logic            cfg_auto_off,
   input  logic            cfg_req_en,
   input  logic            cfg_major_link,
   input  logic [CH_W-1:0] cfg_major_ch,
   input  logic            cfg_minor_link,
   input  logic [CH_W-1:0] cfg_minor_ch,
   input  logic            cont_mode,
   input  logic            hw_req,
   input  logic            sw_start,
   input  logic            cancel,
   input  logic            err_cancel,
   input  logic            clr_int,
   input  logic            clr_done,
   input  logic            clr_err,
   input  logic            rd_done,
   input  logic            wr_done,
   output logic            rd_req,
   output logic            wr_req,
   output logic            minor_done,
   output logic            major_done,
   output logic            int_flag,
   output logic            done_flag,
   output logic            req_en,
   output logic            link_start,
   output logic [CH_W-1:0] link_ch,
   output logic            active,
   output logic [IT_W-1:0] cur_iter,
   output logic            cfg_err,
   output logic            cancel_err
);

   // descriptor fields held for the channel
   logic [NB_W-1:0] nb_q;
   logic [SZ_W-1:0] size_q;
   logic [1:0]      stall_q;
   logic            half_q;
   logic            mjint_q;
   logic            auto_q;
   logic            mjl_q;
   logic [CH_W-1:0] mjch_q;
   logic            mnl_q;
   logic [CH_W-1:0] mnch_q;

   logic valid_q;
   logic start_pend;
   logic cancel_pend;
   logic cancel_kind;

   logic busy;
   logic minor_end;
   logic cut_taken;
   logic last_iter;
   logic chain;
   logic take_load;
   logic bad_cfg;
   logic go;
   logic cut;
   logic cancel_any;

   assign take_load  = cfg_load & ~busy;
   assign bad_cfg    = (cfg_nbytes == '0) | (cfg_biter == '0) | (cfg_biter != cfg_citer);
   assign go         = ~busy & ~cfg_load & valid_q & (start_pend | (hw_req & req_en));
   assign cancel_any = cancel | err_cancel;
   assign cut        = cancel_pend | (busy & cancel_any);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         nb_q    <= '0;
         size_q  <= '0;
         stall_q <= '0;
         half_q  <= 1'b0;
         mjint_q <= 1'b0;
         auto_q  <= 1'b0;
         mjl_q   <= 1'b0;
         mjch_q  <= '0;
         mnl_q   <= 1'b0;
         mnch_q  <= '0;
      end else if (take_load) begin
         nb_q    <= cfg_nbytes;
         size_q  <= cfg_size;
         stall_q <= cfg_stall;
         half_q  <= cfg_int_half;
         mjint_q <= cfg_int_major;
         auto_q  <= cfg_auto_off;
         mjl_q   <= cfg_major_link;
         mjch_q  <= cfg_major_ch;
         mnl_q   <= cfg_minor_link;
         mnch_q  <= cfg_minor_ch;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q     <= 1'b0;
         cfg_err     <= 1'b0;
         req_en      <= 1'b0;
         start_pend  <= 1'b0;
         cancel_pend <= 1'b0;
         cancel_kind <= 1'b0;
         cancel_err  <= 1'b0;
      end else begin
         // descriptor acceptance and configuration error
         if (take_load) begin
            valid_q <= ~bad_cfg;
            cfg_err <= bad_cfg;
         end else if (clr_err) begin
            cfg_err <= 1'b0;
         end
         // hardware request enable with automatic clear
         if (take_load)                            req_en <= cfg_req_en;
         else if (minor_end && last_iter && auto_q) req_en <= 1'b0;
         // software start bit
         if (take_load)     start_pend <= 1'b0;
         else if (go)       start_pend <= 1'b0;
         else if (sw_start) start_pend <= 1'b1;
         // cancel request held until the minor loop retires
         if (minor_end) begin
            cancel_pend <= 1'b0;
            cancel_kind <= 1'b0;
         end else if (busy && cancel_any) begin
            cancel_pend <= 1'b1;
            cancel_kind <= cancel_kind | err_cancel;
         end
         if (cut_taken && cancel_kind) cancel_err <= 1'b1;
         else if (clr_err)             cancel_err <= 1'b0;
      end
   end

   dma_xfer_seq #(
      .NB_W     (NB_W),
      .SZ_W     (SZ_W),
      .STALL_EN (STALL_EN)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .go         (go),
      .chain      (chain),
      .cut        (cut),
      .nbytes     (nb_q),
      .size_log2  (size_q),
      .stall_code (stall_q),
      .rd_done    (rd_done),
      .wr_done    (wr_done),
      .rd_req     (rd_req),
      .wr_req     (wr_req),
      .minor_end  (minor_end),
      .busy       (busy),
      .cut_taken  (cut_taken)
   );

   dma_iter_cnt #(
      .IT_W (IT_W)
   ) u_iter (
      .clk         (clk),
      .rst_n       (rst_n),
      .load        (take_load),
      .ld_biter    (cfg_biter),
      .ld_citer    (cfg_citer),
      .step        (minor_end),
      .half_en     (half_q),
      .major_en    (mjint_q),
      .clr_int     (clr_int),
      .clr_done    (clr_done),
      .citer       (cur_iter),
      .last_iter   (last_iter),
      .int_flag    (int_flag),
      .done_flag   (done_flag),
      .minor_pulse (minor_done),
      .major_pulse (major_done)
   );

   dma_link_sel #(
      .CH_W  (CH_W),
      .CH_ID (CH_ID)
   ) u_link (
      .clk        (clk),
      .rst_n      (rst_n),
      .step       (minor_end),
      .last_iter  (last_iter),
      .cut_taken  (cut_taken),
      .cont_mode  (cont_mode),
      .minor_en   (mnl_q),
      .minor_ch   (mnch_q),
      .major_en   (mjl_q),
      .major_ch   (mjch_q),
      .chain      (chain),
      .link_start (link_start),
      .link_ch    (link_ch)
   );

   assign active = busy;

   // R13
   err_blocks_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |-> !active);

   // R7
   auto_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (major_done && auto_q) |-> !req_en);

   // R12
   cancel_retired_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !active |-> !cancel_pend);

endmodule

// File: tb/dma_loop_ctrl_tb.sv
module dma_loop_ctrl_tb;

   localparam int NB_W  = 16;
   localparam int IT_W  = 9;
   localparam int CH_W  = 5;
   localparam int SZ_W  = 3;
   localparam int CH_ID = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic            cfg_load = 0;
   logic [NB_W-1:0] cfg_nbytes = '0;
   logic [IT_W-1:0] cfg_biter = '0, cfg_citer = '0;
   logic [SZ_W-1:0] cfg_size = '0;
   logic [1:0]      cfg_stall = '0;
   logic cfg_int_half = 0, cfg_int_major = 0, cfg_auto_off = 0, cfg_req_en = 0;
   logic cfg_major_link = 0, cfg_minor_link = 0, cont_mode = 0;
   logic [CH_W-1:0] cfg_major_ch = '0, cfg_minor_ch = '0;
   logic hw_req = 0, sw_start = 0, cancel = 0, err_cancel = 0;
   logic clr_int = 0, clr_done = 0, clr_err = 0;
   logic rd_done = 0, wr_done = 0;
   logic rd_req, wr_req, minor_done, major_done, int_flag, done_flag, req_en;
   logic link_start, active, cfg_err, cancel_err;
   logic [CH_W-1:0] link_ch;
   logic [IT_W-1:0] cur_iter;

   dma_loop_ctrl #(.NB_W(NB_W), .IT_W(IT_W), .CH_W(CH_W), .SZ_W(SZ_W), .CH_ID(CH_ID)) u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_nbytes(cfg_nbytes),
      .cfg_biter(cfg_biter), .cfg_citer(cfg_citer), .cfg_size(cfg_size),
      .cfg_stall(cfg_stall), .cfg_int_half(cfg_int_half), .cfg_int_major(cfg_int_major),
      .cfg_auto_off(cfg_auto_off), .cfg_req_en(cfg_req_en), .cfg_major_link(cfg_major_link),
      .cfg_major_ch(cfg_major_ch), .cfg_minor_link(cfg_minor_link), .cfg_minor_ch(cfg_minor_ch),
      .cont_mode(cont_mode), .hw_req(hw_req), .sw_start(sw_start), .cancel(cancel),
      .err_cancel(err_cancel), .clr_int(clr_int), .clr_done(clr_done), .clr_err(clr_err),
      .rd_done(rd_done), .wr_done(wr_done), .rd_req(rd_req), .wr_req(wr_req),
      .minor_done(minor_done), .major_done(major_done), .int_flag(int_flag),
      .done_flag(done_flag), .req_en(req_en), .link_start(link_start), .link_ch(link_ch),
      .active(active), .cur_iter(cur_iter), .cfg_err(cfg_err), .cancel_err(cancel_err));

   int n_chk = 0, n_bad = 0;
   int n_rd = 0, n_wr = 0, n_minor = 0, n_major = 0, n_link = 0, n_gap = 0, n_act = 0;
   int last_link = 0;
   bit act_prev = 0;

   // bus responder and event monitor
   always @(negedge clk) begin
      if (rd_req && !rd_done) begin rd_done <= 1'b1; n_rd++; end else rd_done <= 1'b0;
      if (wr_req && !wr_done) begin wr_done <= 1'b1; n_wr++; end else wr_done <= 1'b0;
      if (minor_done) n_minor++;
      if (major_done) n_major++;
      if (link_start) begin n_link++; last_link = int'(link_ch); end
      if (active && !rd_req && !wr_req) n_gap++;
      if (active && !act_prev) n_act++;
      act_prev = active;
   end

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int pairs_of(input int nb, input int sz);
      return (nb + (1 << sz) - 1) >> sz;
   endfunction

   function automatic int stall_of(input int code);
      return (code == 2) ? 4 : (code == 3) ? 8 : 0;
   endfunction

   task automatic clear_counts();
      n_rd = 0; n_wr = 0; n_minor = 0; n_major = 0; n_link = 0; n_gap = 0; n_act = 0;
      last_link = -1;
   endtask

   task automatic pulse(ref logic sig);
      @(negedge clk); sig = 1'b1;
      @(negedge clk); sig = 1'b0;
   endtask

   task automatic load_tcd(input int nb, input int bi, input int ci, input int sz, input int st,
                           input bit half, input bit mj, input bit auto_off, input bit reqen,
                           input bit mjl, input int mjch, input bit mnl, input int mnch,
                           input bit cont);
      @(negedge clk);
      cfg_nbytes = NB_W'(nb); cfg_biter = IT_W'(bi); cfg_citer = IT_W'(ci);
      cfg_size = SZ_W'(sz); cfg_stall = 2'(st); cfg_int_half = half; cfg_int_major = mj;
      cfg_auto_off = auto_off; cfg_req_en = reqen; cfg_major_link = mjl;
      cfg_major_ch = CH_W'(mjch); cfg_minor_link = mnl; cfg_minor_ch = CH_W'(mnch);
      cont_mode = cont; cfg_load = 1'b1;
      @(negedge clk); cfg_load = 1'b0;
   endtask

   task automatic run_minor();
      pulse(sw_start);
      while (!active) @(negedge clk);
      while (active) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic run_major();
      int base = n_major;
      for (int k = 0; k < 64 && n_major == base; k++) run_minor();
   endtask

   task automatic wait_rd(input int n);
      while (n_rd < n) begin @(negedge clk); #1; end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'h1d5a));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 active", int'(active), 0);
      chk("R1 req_en", int'(req_en), 0);
      chk("R1 flags", int'({int_flag, done_flag, cfg_err, cancel_err, link_start}), 0);
      chk("R1 cur_iter", int'(cur_iter), 0);

      // R13 configuration errors block starts
      clear_counts();
      load_tcd(0, 3, 3, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
      chk("R13 nbytes zero", int'(cfg_err), 1);
      pulse(sw_start); repeat (20) @(negedge clk);
      chk("R13 no start on error", n_act, 0);
      pulse(clr_err);
      chk("R13 clr_err", int'(cfg_err), 0);
      pulse(sw_start); repeat (20) @(negedge clk);
      chk("R13 still blocked", n_act, 0);
      load_tcd(4, 4, 3, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
      chk("R13 count mismatch", int'(cfg_err), 1);

      // R6 half interrupt, R5 clear, R4 completion without major interrupt
      load_tcd(4, 6, 6, 2, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0);
      chk("R13 good load", int'(cfg_err), 0);
      clear_counts();
      run_minor(); run_minor();
      chk("R6 no early half", int'(int_flag), 0);
      chk("R3 count after two", int'(cur_iter), 4);
      run_minor();
      chk("R6 half reached", int'(int_flag), 1);
      chk("R3 count after three", int'(cur_iter), 3);
      chk("R2 one pair per loop", n_rd, 3);
      pulse(clr_int);
      chk("R5 clr_int", int'(int_flag), 0);
      run_minor(); run_minor(); run_minor();
      chk("R4 major pulse", n_major, 1);
      chk("R4 reload", int'(cur_iter), 6);
      chk("R4 done", int'(done_flag), 1);
      chk("R5 no major int when disabled", int'(int_flag), 0);
      pulse(clr_done);
      chk("R5 clr_done", int'(done_flag), 0);

      // R8 hardware request gating, R7 auto clear of request enable
      load_tcd(2, 3, 3, 0, 0, 0, 1, 1, 0, 0, 0, 0, 0, 0);
      clear_counts();
      hw_req = 1'b1;
      repeat (30) @(negedge clk);
      chk("R8 hw_req ignored without req_en", n_act, 0);
      load_tcd(2, 3, 3, 0, 0, 0, 1, 1, 1, 0, 0, 0, 0, 0);
      for (int k = 0; k < 400 && n_major == 0; k++) @(negedge clk);
      repeat (30) @(negedge clk);
      chk("R8 hw_req runs", n_minor, 3);
      chk("R7 req_en cleared", int'(req_en), 0);
      chk("R5 major int", int'(int_flag), 1);
      hw_req = 1'b0;
      pulse(clr_int); pulse(clr_done);

      // R12 cancel after current pair
      load_tcd(16, 4, 4, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
      clear_counts();
      pulse(sw_start);
      wait_rd(3);
      cancel = 1'b1; @(negedge clk); cancel = 1'b0;
      while (active) @(negedge clk);
      @(negedge clk);
      chk("R12 cancel pairs", n_rd, 3);
      chk("R12 cancel write count", n_wr, 3);
      chk("R12 retired as minor", n_minor, 1);
      chk("R12 count stepped", int'(cur_iter), 3);
      chk("R12 plain cancel no error", int'(cancel_err), 0);
      clear_counts();
      pulse(sw_start);
      wait_rd(5);
      err_cancel = 1'b1; @(negedge clk); err_cancel = 1'b0;
      while (active) @(negedge clk);
      @(negedge clk);
      chk("R12 error cancel pairs", n_rd, 5);
      chk("R12 error flag", int'(cancel_err), 1);
      pulse(cancel);
      clear_counts();
      run_minor();
      chk("R12 idle cancel ignored", n_rd, 16);
      pulse(clr_err);
      chk("R13 clr_err clears cancel", int'(cancel_err), 0);

      // R11 continuous self link with R10 major link
      load_tcd(3, 4, 4, 0, 0, 0, 0, 0, 0, 1, 9, 1, CH_ID, 1);
      clear_counts();
      run_major();
      chk("R11 single activation", n_act, 1);
      chk("R11 all minors", n_minor, 4);
      chk("R10 only major link", n_link, 1);
      chk("R10 major link ch", last_link, 9);
      pulse(clr_done);

      // random descriptors, R2 R3 R4 R9 R10 R11
      for (int t = 0; t < 24; t++) begin
         int nb, sz, bi, st, mjch, mnch, exp_link, exp_last, pr;
         bit half, mj, mjl, mnl, cont, selfl;
         nb = 1 + int'($urandom % 24);
         sz = int'($urandom % 4);
         bi = 1 + int'($urandom % 6);
         st = int'($urandom % 4);
         half = 1'($urandom); mj = 1'($urandom);
         mjl = 1'($urandom); mnl = 1'($urandom); cont = 1'($urandom);
         mjch = int'($urandom % 32);
         mnch = ($urandom % 2 == 0) ? CH_ID : int'($urandom % 32);
         selfl = mnl && cont && (mnch == CH_ID);
         pr = pairs_of(nb, sz);
         pulse(clr_int); pulse(clr_done);
         load_tcd(nb, bi, bi, sz, st, half, mj, 0, 0, mjl, mjch, mnl, mnch, cont);
         clear_counts();
         run_major();
         exp_link = (mjl ? 1 : 0) + ((mnl && !selfl) ? (bi - 1) : 0);
         exp_last = mjl ? mjch : ((mnl && !selfl && bi > 1) ? mnch : -1);
         chk("R2 reads", n_rd, bi * pr);
         chk("R2 writes", n_wr, bi * pr);
         chk("R9 idle cycles", n_gap, bi * (pr * stall_of(st) + 1));
         chk("R3 minor pulses", n_minor, bi);
         chk("R4 reload", int'(cur_iter), bi);
         chk("R4 done", int'(done_flag), 1);
         chk("R6 R5 int", int'(int_flag), int'(mj | half));
         chk("R10 link pulses", n_link, exp_link);
         chk("R10 last link ch", last_link, exp_last);
         chk("R11 activations", n_act, selfl ? 1 : bi);
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule